// File: doc/BRIEF.md
# Debug Port Mode Selection Monitor

This block sits on the target side of a two-wire or four-wire debug port. It watches the shared mode/data line on every rising edge of the debug clock. From what it sees, it works out whether the port should behave as a JTAG port, as a serial-wire port, or stay dormant. Every sample is taken only while `line_en` is high, which is the window in which the port itself is not driving the line. The transaction engine and the TAP controller downstream use the `mode` output to decide which of them owns the pins.

The detector builds on runs of consecutive high samples. A run of 50 or more highs arms the switch and line-reset logic, and a run of 5 or more highs in JTAG mode means the TAP has reached Test-Logic-Reset. In the dormant state a 128-bit alert pattern must arrive after at least 8 highs. It is followed by four low samples and an activation code, which wakes the port in the selected protocol. Every bit pattern is sent least significant bit first. The outputs are registered, so each result appears right after the clock edge that samples the bit completing it.

Top module: `dbg_mode_detect`

## Requirements
- R1: In serial-wire mode, a low sample taken after a run of at least 50 consecutive high samples raises `line_reset` for exactly one cycle. A low sample after only 49 highs does not raise it.
- R2: In JTAG mode, a low sample after at least 50 highs starts a window. If that sample and the next 15 samples form 16'hE79E (bit 0 first), the mode becomes serial-wire.
- R3: In serial-wire mode, the same window holding 16'hE73C switches the mode to JTAG.
- R4: In serial-wire mode, the same window holding 16'hE3BC switches the mode to dormant.
- R5: In JTAG mode, a low sample after at least 5 highs starts a 31-sample window. If the window holds 31'h33BBBBBA (bit 0 first), the mode becomes dormant. After only 4 highs the pattern has no effect.
- R6: In dormant mode, a 128-sample alert pattern is accepted only if it begins with a low sample after at least 8 highs and every bit matches. The pattern is 128'h19BC0EA2E3DDAFE986852D956209F392, sent bit 0 first. A corrupted alert, or one after only 7 highs, leaves the port dormant.
- R7: After an accepted alert, the next 4 samples must be low and are followed by an activation code, bit 0 first. The code 8'h1A selects serial-wire, 8'h0A selects JTAG, and twelve zero bits select JTAG.
- R8: If the activation code matches none of these, the port stays dormant and needs a new alert.
- R9: A clock edge with `line_en` low has no effect on any state or output, and `line_reset` and `mode_change` stay low on it.
- R10: After reset the mode is JTAG. The `mode` encoding is 0 for JTAG, 1 for serial-wire and 2 for dormant.
- R11: `mode_change` is high for one cycle exactly when `mode` takes a new value. Both update on the edge that samples the bit completing the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_en | input | 1 | High when the line is not driven by the port and may be sampled |
| line_in | input | 1 | Mode/data line value |
| mode | output | 2 | Current port mode: 0 JTAG, 1 serial-wire, 2 dormant |
| line_reset | output | 1 | One-cycle pulse on a completed line reset |
| mode_change | output | 1 | One-cycle pulse when `mode` changes |

## Verification
Every result of this block is due on the same rising edge that samples the bit completing it. The line-reset pulse comes on the edge of the first low sample. A mode switch and its pulse come on the edge of the last pattern bit or the last activation-code bit. The bench changes the line on the falling edge and reads the outputs 2 ns after each rising edge. A behavioural model, working from the history of sampled bits, predicts the mode and both pulses for that same edge, and every cycle is compared against it. Checks at the end of each scenario confirm the mode reached.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

    typedef enum logic [1:0] {
        MODE_JTAG = 2'd0,
        MODE_SWD  = 2'd1,
        MODE_DORM = 2'd2
    } dmode_e;

    localparam int CAP_W = 31;
    localparam int CNT_W = $clog2(CAP_W + 1);

    localparam logic [15:0]      PAT_J2S  = 16'hE79E;
    localparam logic [15:0]      PAT_S2J  = 16'hE73C;
    localparam logic [15:0]      PAT_S2D  = 16'hE3BC;
    localparam logic [CAP_W-1:0] PAT_J2D  = 31'h33BBBBBA;
    localparam logic [7:0]       CODE_SWD = 8'h1A;
    localparam logic [7:0]       CODE_JTG = 8'h0A;
    localparam logic [127:0]     ALERT    = 128'h19BC0EA2E3DDAFE986852D956209F392;

    typedef struct packed {
        dmode_e             mode;
        logic               act;
        logic               lng;
        logic [CAP_W-1:0]   cap;
        logic [CNT_W-1:0]   cnt;
        logic               lr;
        logic               mc;
    } det_st_t;

endpackage

// File: rtl/dbg_mode_runcnt.sv
module dbg_mode_runcnt #(
    parameter int LIMIT = 50,
    localparam int RW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_in,
    output logic [RW-1:0] run
);
    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (en) begin
            if (!bit_in)                   run_d = '0;
            else if (run_q != RW'(LIMIT))  run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign run = run_q;

    assert_run_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(LIMIT));
    assert_run_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(bit_in)) |-> (run_q == '0));
endmodule

// File: rtl/dbg_mode_alert.sv
module dbg_mode_alert
    import dbg_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic primed,
    input  logic bit_in,
    output logic hit
);
    localparam int LEN = $bits(ALERT);
    localparam int CW  = $clog2(LEN + 1);

    typedef struct packed {
        logic [LEN-1:0] sh;
        logic [CW-1:0]  cnt;
    } al_st_t;

    al_st_t cur, nx;

    always_comb begin
        nx  = cur;
        hit = 1'b0;
        if (clr) begin
            nx.cnt = '0;
        end else if (en) begin
            nx.sh = {bit_in, cur.sh[LEN-1:1]};
            if (!bit_in && primed)  nx.cnt = CW'(1);
            else if (cur.cnt != '0) nx.cnt = cur.cnt + 1'b1;
            if (nx.cnt == CW'(LEN)) begin
                hit    = (nx.sh == ALERT);
                nx.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '0;
        else        cur <= nx;
    end

    assert_alert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur.cnt < CW'(LEN));
    assert_alert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cur.cnt == '0));
endmodule

// File: rtl/dbg_mode_detect.sv
module dbg_mode_detect
    import dbg_mode_pkg::*;
#(
    parameter int RUN_LONG  = 50,
    parameter int RUN_TLR   = 5,
    parameter int RUN_PRIME = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_en,
    input  logic       line_in,
    output logic [1:0] mode,
    output logic       line_reset,
    output logic       mode_change
);
    localparam int RW = $clog2(RUN_LONG + 1);

    det_st_t          cur, nx;
    logic [RW-1:0]    run;
    logic [CNT_W-1:0] cnt_inc;
    logic             ge_long, ge_tlr, ge_prime;
    logic             alert_en, alert_clr, alert_hit;

    dbg_mode_runcnt #(.LIMIT(RUN_LONG)) u_run (
        .clk(clk), .rst_n(rst_n), .en(line_en), .bit_in(line_in), .run(run)
    );

    assign ge_long   = (run >= RW'(RUN_LONG));
    assign ge_tlr    = (run >= RW'(RUN_TLR));
    assign ge_prime  = (run >= RW'(RUN_PRIME));
    assign alert_clr = !(cur.mode == MODE_DORM && !cur.act);
    assign alert_en  = line_en && !alert_clr;

    dbg_mode_alert u_alert (
        .clk(clk), .rst_n(rst_n), .en(alert_en), .clr(alert_clr),
        .primed(ge_prime), .bit_in(line_in), .hit(alert_hit)
    );

    assign cnt_inc = cur.cnt + 1'b1;

    always_comb begin
        nx    = cur;
        nx.lr = 1'b0;
        nx.mc = 1'b0;
        if (line_en) begin
            nx.cap = {line_in, cur.cap[CAP_W-1:1]};
            unique case (cur.mode)
                MODE_JTAG: begin
                    if (!line_in && ge_tlr) begin
                        nx.cnt = CNT_W'(1);
                        nx.lng = ge_long;
                    end else if (cur.cnt != '0) begin
                        nx.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(16) && cur.lng && nx.cap[CAP_W-1:CAP_W-16] == PAT_J2S) begin
                            nx.mode = MODE_SWD;
                            nx.mc   = 1'b1;
                            nx.cnt  = '0;
                        end else if (cnt_inc == CNT_W'(CAP_W)) begin
                            nx.cnt = '0;
                            if (nx.cap == PAT_J2D) begin
                                nx.mode = MODE_DORM;
                                nx.mc   = 1'b1;
                            end
                        end
                    end
                end
                MODE_SWD: begin
                    if (!line_in && ge_long) begin
                        nx.lr  = 1'b1;
                        nx.cnt = CNT_W'(1);
                    end else if (cur.cnt != '0) begin
                        nx.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(16)) begin
                            nx.cnt = '0;
                            if (nx.cap[CAP_W-1:CAP_W-16] == PAT_S2J) begin
                                nx.mode = MODE_JTAG;
                                nx.mc   = 1'b1;
                            end else if (nx.cap[CAP_W-1:CAP_W-16] == PAT_S2D) begin
                                nx.mode = MODE_DORM;
                                nx.mc   = 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    if (!cur.act) begin
                        if (alert_hit) begin
                            nx.act = 1'b1;
                            nx.cnt = '0;
                        end
                    end else begin
                        nx.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(12)) begin
                            if (nx.cap[CAP_W-1:CAP_W-12] == {CODE_SWD, 4'h0}) begin
                                nx.mode = MODE_SWD;
                                nx.mc   = 1'b1;
                                nx.act  = 1'b0;
                                nx.cnt  = '0;
                            end else if (nx.cap[CAP_W-1:CAP_W-12] == {CODE_JTG, 4'h0}) begin
                                nx.mode = MODE_JTAG;
                                nx.mc   = 1'b1;
                                nx.act  = 1'b0;
                                nx.cnt  = '0;
                            end else if (nx.cap[CAP_W-1:CAP_W-12] != '0) begin
                                nx.act = 1'b0;
                                nx.cnt = '0;
                            end
                        end else if (cnt_inc == CNT_W'(16)) begin
                            nx.act = 1'b0;
                            nx.cnt = '0;
                            if (nx.cap[CAP_W-1:CAP_W-16] == '0) begin
                                nx.mode = MODE_JTAG;
                                nx.mc   = 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= '0;
            cur.mode <= MODE_JTAG;
        end else begin
            cur <= nx;
        end
    end

    assign mode        = cur.mode;
    assign line_reset  = cur.lr;
    assign mode_change = cur.mc;

    assert_lr_only_swd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cur.lr |-> ($past(cur.mode) == MODE_SWD));
    assert_change_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.mode != $past(cur.mode)) |-> cur.mc);
    assert_flag_real_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cur.mc |-> (cur.mode != $past(cur.mode)));
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_en) |-> ($stable(cur.mode) && !cur.lr && !cur.mc));
    assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur.mode != 2'd3);
endmodule

// File: tb/dbg_mode_detect_test.sv
module dbg_mode_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_en = 1'b0;
    logic line_in = 1'b0;
    logic [1:0] mode;
    logic line_reset, mode_change;

    localparam logic [127:0] ALERT_V = 128'h19BC0EA2E3DDAFE986852D956209F392;

    int checks = 0;
    int fails  = 0;

    int mhc = 0;
    int mmode = 0;
    bit macts = 0;
    int since = 0;
    bit hist[$];
    int runb[$];
    bit aq[$];
    bit exp_lr, exp_mc;

    always #4 clk = ~clk;

    dbg_mode_detect uut (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .line_in(line_in),
        .mode(mode), .line_reset(line_reset), .mode_change(mode_change)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit win(input logic [127:0] p, input int len, input int thr);
        int n = hist.size();
        if (since < len || n < len) return 0;
        if (runb[n-len] < thr) return 0;
        for (int i = 0; i < len; i++)
            if (hist[n-len+i] != p[i]) return 0;
        return 1;
    endfunction

    task automatic model(input bit b);
        int newm = mmode;
        int v = 0;
        exp_lr = 0;
        exp_mc = 0;
        hist.push_back(b);
        runb.push_back(mhc);
        since++;
        if (hist.size() > 200) begin
            void'(hist.pop_front());
            void'(runb.pop_front());
        end
        if (mmode == 1) begin
            if (!b && mhc >= 50) exp_lr = 1;
            if (win(128'hE73C, 16, 50)) newm = 0;
            else if (win(128'hE3BC, 16, 50)) newm = 2;
        end else if (mmode == 0) begin
            if (win(128'hE79E, 16, 50)) newm = 1;
            else if (win(128'h33BBBBBA, 31, 5)) newm = 2;
        end else if (macts) begin
            aq.push_back(b);
            for (int i = 0; i < aq.size(); i++) v |= int'(aq[i]) << i;
            if (aq.size() == 12) begin
                if (v == 'h1A0) newm = 1;
                else if (v == 'h0A0) newm = 0;
                else if (v != 0) begin macts = 0; since = 0; end
            end else if (aq.size() == 16) begin
                macts = 0; since = 0;
                if (v == 0) newm = 0;
            end
        end else if (win(ALERT_V, 128, 8)) begin
            macts = 1; aq.delete(); since = 0;
        end
        if (newm != mmode) begin
            mmode = newm; exp_mc = 1; since = 0; macts = 0;
        end
        mhc = b ? ((mhc < 50) ? mhc + 1 : 50) : 0;
    endtask

    task automatic step(input bit en, input bit b);
        line_en = en;
        line_in = b;
        @(posedge clk);
        if (en) model(b);
        else begin exp_lr = 0; exp_mc = 0; end
        #2;
        chk(int'(mode), mmode, "R10 mode vs model");
        chk(int'(line_reset), int'(exp_lr), "R1 line_reset vs model");
        chk(int'(mode_change), int'(exp_mc), "R11 mode_change vs model");
        @(negedge clk);
    endtask

    task automatic highs(input int n);
        for (int i = 0; i < n; i++) step(1, 1);
    endtask

    task automatic bits(input logic [127:0] v, input int len);
        for (int i = 0; i < len; i++) step(1, v[i]);
    endtask

    task automatic wake(input int prime, input logic [127:0] al, input logic [15:0] code, input int clen);
        step(1, 0);
        highs(prime);
        bits(al, 128);
        bits(128'h0, 4);
        bits(128'(code), clen);
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(int'(mode), 0, "R10 reset mode JTAG");
        chk(int'(line_reset), 0, "R10 reset line_reset");
        chk(int'(mode_change), 0, "R10 reset mode_change");

        highs(60); bits(128'hE79E, 16);
        chk(int'(mode), 1, "R2 JTAG to serial-wire");

        step(1, 0); highs(49); step(1, 0);
        chk(int'(line_reset), 0, "R1 no line reset after 49 highs");
        highs(50); step(1, 0);
        chk(int'(line_reset), 1, "R1 line reset after 50 highs");
        bits(128'h0, 5);

        highs(55); bits(128'hE73C, 16);
        chk(int'(mode), 0, "R3 serial-wire to JTAG");

        highs(60);
        for (int i = 0; i < 20; i++) step(0, i[0]);
        bits(128'hE79E, 16);
        chk(int'(mode), 1, "R9 disabled samples ignored");

        highs(52); bits(128'hE3BC, 16);
        chk(int'(mode), 2, "R4 serial-wire to dormant");

        wake(7, ALERT_V, 16'h1A, 8);
        chk(int'(mode), 2, "R6 alert after 7 highs ignored");
        wake(10, ALERT_V ^ (128'd1 << 40), 16'h1A, 8);
        chk(int'(mode), 2, "R6 corrupted alert ignored");
        wake(10, ALERT_V, 16'h1A, 8);
        chk(int'(mode), 1, "R7 code 1A selects serial-wire");

        highs(50); bits(128'hE3BC, 16);
        wake(9, ALERT_V, 16'h55, 8);
        chk(int'(mode), 2, "R8 bad code stays dormant");
        wake(9, ALERT_V, 16'h0A, 8);
        chk(int'(mode), 0, "R7 code 0A selects JTAG");

        step(1, 0); highs(4); bits(128'h33BBBBBA, 31);
        chk(int'(mode), 0, "R5 pattern after 4 highs ignored");
        step(1, 0); highs(6); bits(128'h33BBBBBA, 31);
        chk(int'(mode), 2, "R5 JTAG to dormant");

        wake(8, ALERT_V, 16'h0000, 12);
        chk(int'(mode), 0, "R7 twelve zeros select JTAG");

        highs(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule